// File: doc/BRIEF.md
# Segmented Condition Register

This block holds a 32-bit condition register split into eight 4-bit fields. Three kinds of update can write into it. A compare of two operands writes its outcome into any field it names. A fixed-point result that carries a record flag refreshes field 0. A floating-point exception summary that carries a record flag refreshes field 1. A sticky summary-overflow flag is kept beside the register. Every compare and every fixed-point record copies this flag into the SO bit of the field it writes.

Bit numbering is big endian: bit 0 of the register is the most significant bit of the `cr_out` vector. A 5-bit index selects any single register bit as a branch condition, and the selected bit is presented combinationally from the stored register. All writes take effect at the rising clock edge after the update is presented.

Top module: `cond_reg_unit`

## Requirements
- R1: After reset, `cr_out` is all zeros, `sel_bit` is 0 and the sticky overflow flag is clear.
- R2: Register bit i (big endian, 0..31) is `cr_out[31-i]`. Field k covers register bits 4k..4k+3, which is `cr_out[31-4k -: 4]`. Inside a field the register bits in ascending order are LT, GT, EQ, SO, so LT is the most significant bit of the field's slice.
- R3: When `cmp_valid` is 1, the field numbered by `cmp_field` receives exactly one of LT, GT or EQ on the next edge. The compare is signed (two's complement) when `cmp_signed` is 1 and unsigned when it is 0.
- R4: The SO bit written by a compare or by a fixed-point record equals the sticky flag's value after this cycle's update, that is `ovf_event | (flag & ~so_clear)`.
- R5: When `fx_rec_valid` is 1, field 0 receives LT if `fx_result` is negative (bit 31 set), GT if it is positive and nonzero, or EQ if it is zero.
- R6: When `fp_rec_valid` is 1, field 1 receives `fp_flags[3:0]` unchanged, in the order exception summary (LT position), enabled-exception summary, invalid-operation summary, overflow (SO position).
- R7: The sticky flag is set by `ovf_event` and keeps its value until `so_clear` is asserted. When both are asserted in the same cycle, the flag ends up set.
- R8: When a compare and a record update target the same field in the same cycle, the compare's value is written.
- R9: A field that no update targets in a cycle keeps its value.
- R10: `sel_bit` equals register bit `sel_index` (big endian) of the current `cr_out`, with no clock delay.
- R11: A fixed-point record, a floating-point record and a compare to a third field may all apply in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmp_valid | input | 1 | Compare update this cycle |
| cmp_signed | input | 1 | 1: signed compare, 0: unsigned |
| cmp_a | input | 32 | Left compare operand |
| cmp_b | input | 32 | Right compare operand |
| cmp_field | input | 3 | Destination field of the compare |
| fx_rec_valid | input | 1 | Fixed-point result with record flag |
| fx_result | input | 32 | Fixed-point result value |
| fp_rec_valid | input | 1 | Floating-point result with record flag |
| fp_flags | input | 4 | Floating-point exception summaries |
| ovf_event | input | 1 | Overflow occurred this cycle |
| so_clear | input | 1 | Clear the sticky overflow flag |
| sel_index | input | 5 | Big-endian bit index for branch test |
| cr_out | output | 32 | Full condition register |
| sel_bit | output | 1 | Selected register bit |

## Verification
A wrong field index or a reversed bit order shows up in `cr_out` one edge after the update that causes it. It also shows up at once on `sel_bit` when that bit is indexed. A corrupted sticky flag stays hidden until the next compare or fixed-point record copies it into an SO bit. For that reason the bench drives overflow, clear and idle cycles and then issues a write to make the flag visible. A priority error needs a compare and a record that collide on the same field, so those collisions are driven on purpose.

// File: rtl/cru_pkg.sv
package cru_pkg;
    localparam int CR_FIELDS = 8;
    localparam int FLD_W     = 4;
    localparam int CR_W      = CR_FIELDS * FLD_W;
    localparam int IDX_W     = $clog2(CR_W);
    localparam int FSEL_W    = $clog2(CR_FIELDS);

    typedef struct packed {
        logic [CR_FIELDS-1:0][FLD_W-1:0] fld;
        logic                            so;
    } cru_state_t;

    typedef struct packed {
        logic lt;
        logic gt;
        logic eq;
    } cru_rel_t;
endpackage

// File: rtl/cru_compare.sv
module cru_compare #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              signed_mode,
    output cru_pkg::cru_rel_t rel
);
    logic lt_s, lt_u, eq_w;

    always_comb begin
        lt_s = $signed(a) < $signed(b);
        lt_u = a < b;
        eq_w = (a == b);
        rel.eq = eq_w;
        rel.lt = signed_mode ? lt_s : lt_u;
        rel.gt = !eq_w && !rel.lt;
    end

    always_comb begin
        AST_CMP_ONE_OUTCOME: assert ($countones({rel.lt, rel.gt, rel.eq}) == 1 || $isunknown({a, b, signed_mode})); // R3
    end
endmodule

// File: rtl/cru_fx_record.sv
module cru_fx_record #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] result,
    output cru_pkg::cru_rel_t rel
);
    always_comb begin
        rel.lt = result[DATA_W-1];
        rel.eq = (result == '0);
        rel.gt = !result[DATA_W-1] && (result != '0);
    end
endmodule

// File: rtl/cru_bit_pick.sv
module cru_bit_pick (
    input  logic [cru_pkg::CR_W-1:0]  cr,
    input  logic [cru_pkg::IDX_W-1:0] idx,
    output logic                      bit_o
);
    localparam int LAST = cru_pkg::CR_W - 1;
    logic [cru_pkg::IDX_W-1:0] flip;

    always_comb begin
        flip  = cru_pkg::IDX_W'(LAST) - idx;
        bit_o = cr[flip];
    end
endmodule

// File: rtl/cond_reg_unit.sv
module cond_reg_unit #(
    parameter int DATA_W = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cmp_valid,
    input  logic                       cmp_signed,
    input  logic [DATA_W-1:0]          cmp_a,
    input  logic [DATA_W-1:0]          cmp_b,
    input  logic [cru_pkg::FSEL_W-1:0] cmp_field,
    input  logic                       fx_rec_valid,
    input  logic [DATA_W-1:0]          fx_result,
    input  logic                       fp_rec_valid,
    input  logic [cru_pkg::FLD_W-1:0]  fp_flags,
    input  logic                       ovf_event,
    input  logic                       so_clear,
    input  logic [cru_pkg::IDX_W-1:0]  sel_index,
    output logic [cru_pkg::CR_W-1:0]   cr_out,
    output logic                       sel_bit
);
    import cru_pkg::*;

    cru_state_t st_d, st_q;
    cru_rel_t   cmp_rel, fx_rel;

    cru_compare #(.DATA_W(DATA_W)) u_cmp (
        .a(cmp_a), .b(cmp_b), .signed_mode(cmp_signed), .rel(cmp_rel)
    );

    cru_fx_record #(.DATA_W(DATA_W)) u_fx (
        .result(fx_result), .rel(fx_rel)
    );

    always_comb begin
        st_d    = st_q;
        st_d.so = ovf_event | (st_q.so & ~so_clear);
        if (fx_rec_valid)
            st_d.fld[0] = {fx_rel.lt, fx_rel.gt, fx_rel.eq, st_d.so};
        if (fp_rec_valid)
            st_d.fld[1] = fp_flags;
        if (cmp_valid)
            st_d.fld[cmp_field] = {cmp_rel.lt, cmp_rel.gt, cmp_rel.eq, st_d.so};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar k = 0; k < CR_FIELDS; k++) begin : g_map
        assign cr_out[CR_W-1-k*FLD_W -: FLD_W] = st_q.fld[k];

        if (k >= 2) begin : g_hold
            AST_FIELD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                !(cmp_valid && cmp_field == k) |=> $stable(cr_out[CR_W-1-k*FLD_W -: FLD_W])); // R9
        end
    end

    cru_bit_pick u_pick (.cr(cr_out), .idx(sel_index), .bit_o(sel_bit));

    AST_SO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.so && !so_clear |=> st_q.so); // R7

    AST_SO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_event |=> st_q.so); // R7

    AST_FP_RECORD: assert property (@(posedge clk) disable iff (!rst_n)
        fp_rec_valid && !(cmp_valid && cmp_field == 1) |=> cr_out[27:24] == $past(fp_flags)); // R6

    AST_FX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        fx_rec_valid && !(cmp_valid && cmp_field == 0) |=> cr_out[29] == ($past(fx_result) == '0)); // R5

    AST_CMP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_valid && cmp_field == 0 && fx_rec_valid |=>
        cr_out[29] == ($past(cmp_a) == $past(cmp_b))); // R8
endmodule

// File: tb/cond_reg_unit_bench.sv
module cond_reg_unit_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 0, rst_n = 0;
    logic        cmp_valid = 0, cmp_signed = 0;
    logic [31:0] cmp_a = 0, cmp_b = 0;
    logic [2:0]  cmp_field = 0;
    logic        fx_rec_valid = 0;
    logic [31:0] fx_result = 0;
    logic        fp_rec_valid = 0;
    logic [3:0]  fp_flags = 0;
    logic        ovf_event = 0, so_clear = 0;
    logic [4:0]  sel_index = 0;
    logic [31:0] cr_out;
    logic        sel_bit;

    int errors = 0, checks = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic [31:0] cr_m = 0;
    logic        so_m = 0;
    bit          done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cond_reg_unit u_cond_reg_unit (
        .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cmp_signed(cmp_signed),
        .cmp_a(cmp_a), .cmp_b(cmp_b), .cmp_field(cmp_field),
        .fx_rec_valid(fx_rec_valid), .fx_result(fx_result),
        .fp_rec_valid(fp_rec_valid), .fp_flags(fp_flags),
        .ovf_event(ovf_event), .so_clear(so_clear), .sel_index(sel_index),
        .cr_out(cr_out), .sel_bit(sel_bit)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic void put_field(int k, logic [3:0] v);
        cr_m[31-4*k -: 4] = v;
    endfunction

    function automatic logic [2:0] rel_of(logic [31:0] a, logic [31:0] b, logic sgn);
        logic lt;
        lt = sgn ? ($signed(a) < $signed(b)) : (a < b);
        if (a == b) return 3'b001;
        return lt ? 3'b100 : 3'b010;
    endfunction

    // driver: applies one cycle of stimulus and queues the expected register
    task automatic drive(string tag,
                         logic cv, logic cs, logic [31:0] a, logic [31:0] b, logic [2:0] f,
                         logic xv, logic [31:0] xr, logic pv, logic [3:0] pf,
                         logic ov, logic cl);
        logic so_n;
        @(negedge clk);
        cmp_valid = cv; cmp_signed = cs; cmp_a = a; cmp_b = b; cmp_field = f;
        fx_rec_valid = xv; fx_result = xr; fp_rec_valid = pv; fp_flags = pf;
        ovf_event = ov; so_clear = cl;
        so_n = ov | (so_m & ~cl);
        if (xv) put_field(0, {rel_of(xr, 32'd0, 1'b1), so_n});
        if (pv) put_field(1, pf);
        if (cv) put_field(int'(f), {rel_of(a, b, cs), so_n});
        so_m = so_n;
        @(posedge clk); #1;
        exp_q.push_back(cr_m); tag_q.push_back(tag);
        cmp_valid = 0; fx_rec_valid = 0; fp_rec_valid = 0; ovf_event = 0; so_clear = 0;
    endtask

    // monitor: compares each queued expectation after its edge
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front(); t = tag_q.pop_front();
            check(t, cr_out, e);
        end
    end

    task automatic idle(string tag);
        drive(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #(CLK_PERIOD*200000);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD*2 + 2);
        check("R1 reset cr", cr_out, 32'h0);
        check("R1 reset sel", {31'b0, sel_bit}, 32'h0);
        rst_n = 1;
        // R1: sticky flag clear after reset -> compare writes SO=0
        drive("R1 so clear after reset", 1, 0, 5, 5, 3'd7, 0, 0, 0, 0, 0, 0);
        // R3 unsigned vs signed on same operands
        drive("R3 unsigned gt", 1, 0, 32'hFFFF_FFFF, 1, 3'd2, 0, 0, 0, 0, 0, 0);
        drive("R3 signed lt", 1, 1, 32'hFFFF_FFFF, 1, 3'd3, 0, 0, 0, 0, 0, 0);
        drive("R3 equal", 1, 1, 32'h8000_0000, 32'h8000_0000, 3'd4, 0, 0, 0, 0, 0, 0);
        drive("R3 R2 field5 lt", 1, 0, 3, 9, 3'd5, 0, 0, 0, 0, 0, 0);
        // R5 fixed-point record
        drive("R5 negative", 0, 0, 0, 0, 0, 1, 32'h8000_0001, 0, 0, 0, 0);
        drive("R5 zero", 0, 0, 0, 0, 0, 1, 32'h0, 0, 0, 0, 0);
        drive("R5 positive", 0, 0, 0, 0, 0, 1, 32'h7FFF_FFFF, 0, 0, 0, 0);
        // R6 floating-point record
        drive("R6 fp flags", 0, 0, 0, 0, 0, 0, 0, 1, 4'b1010, 0, 0);
        drive("R6 fp flags 2", 0, 0, 0, 0, 0, 0, 0, 1, 4'b0101, 0, 0);
        // R7 / R4 sticky overflow
        drive("R7 ovf only", 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
        idle("R9 idle hold");
        drive("R4 R7 so still set", 1, 0, 1, 2, 3'd6, 0, 0, 0, 0, 0, 0);
        drive("R4 fx so", 0, 0, 0, 0, 0, 1, 32'h5, 0, 0, 0, 0);
        drive("R7 set beats clear", 1, 0, 2, 1, 3'd2, 0, 0, 0, 0, 1, 1);
        drive("R7 clear", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
        drive("R4 so cleared", 1, 0, 2, 2, 3'd2, 0, 0, 0, 0, 0, 0);
        drive("R4 same-cycle ovf", 1, 0, 2, 2, 3'd3, 0, 0, 0, 0, 1, 0);
        drive("R7 clear2", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
        // R8 collisions
        drive("R8 cmp over fx", 1, 0, 7, 7, 3'd0, 1, 32'h8000_0000, 0, 0, 0, 0);
        drive("R8 cmp over fp", 1, 1, 1, 32'hFFFF_FFFF, 3'd1, 0, 0, 1, 4'b1111, 0, 0);
        // R11 all three together
        drive("R11 triple", 1, 0, 0, 1, 3'd7, 1, 32'h0, 1, 4'b0110, 0, 0);
        idle("R9 final hold");
        @(negedge clk); @(negedge clk);
        // R10 / R2 combinational bit select
        for (int i = 0; i < 32; i++) begin
            sel_index = 5'(i);
            #1;
            check($sformatf("R10 R2 sel bit %0d", i), {31'b0, sel_bit}, {31'b0, cr_m[31-i]});
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule